// File: doc/BRIEF.md
# Programmable CRC-32 Register Unit

This block computes a 32-bit cyclic redundancy check under software control over a small 32-bit register bus. Registers sit at byte offsets and each write carries one strobe per byte lane. Software programs a starting value and a generator polynomial, then sets a control word that selects how input bits are reflected and whether the result is bit-reversed on read. A control write with the load bit set copies the starting value into the running accumulator.

Data is then written to the data register. A write with only the lowest lane enabled absorbs one byte, and a write with all four lanes enabled absorbs a full 32-bit word in a single update. The accumulator is updated at the clock edge that ends the write. A read of the data register returns the running value, so software can save a partial result and later resume from it by programming it as the starting value. Byte and word input can be mixed freely inside one message by rewriting the control word without the load bit.

Top module: `crc32_regblk`

## Requirements
- R1: After reset, the data register reads 0xFFFFFFFF, the control register reads 0, the starting-value register reads 0xFFFFFFFF and the polynomial register reads 0x04C11DB7.
- R2: The registers sit at byte offsets 0x00 (data), 0x08 (control), 0x10 (starting value) and 0x14 (polynomial). Any other offset reads 0. Writes to the starting-value and polynomial registers update only the byte lanes whose strobe is set, and they leave the accumulator unchanged.
- R3: A control write with strobe lane 0 set and bit 0 equal to 1 copies the starting value into the accumulator at that clock edge. Bit 0 always reads back as 0.
- R4: A data write with strobe 4'b1111 absorbs all 32 bits of the write data, most significant bit first. Each bit XORs the feedback (accumulator bit 31 XOR data bit) into the left-shifted accumulator through the programmed polynomial, whose x^32 term is implicit.
- R5: A data write with strobe 4'b0001 absorbs the 8 bits of write data bits [7:0] in the same way, bit 7 first.
- R6: For 32-bit data writes, control bits [6:5] select input reflection: 2'b00 none, 2'b01 bit order reversed inside each byte, 2'b10 reversed inside each 16-bit half, 2'b11 reversed across the whole word.
- R7: For byte data writes, any nonzero value of control bits [6:5] reverses the 8 data bits before absorption, and 2'b00 leaves them as written.
- R8: Control bit 7 set makes a data-register read return the bit-reversed accumulator. The control register reads back bits 7, 6 and 5 as written, with all other bits 0.
- R9: A control write with bit 0 equal to 0 changes only the mode bits and leaves the accumulator unchanged, so a message can switch between byte and word input partway through.
- R10: A data write with any strobe pattern other than 4'b0001 or 4'b1111 leaves the accumulator unchanged. A control write whose strobe lane 0 is clear leaves the control register and the accumulator unchanged.
- R11: A data read in the cycle right after a data write returns the updated value, and reads never change the accumulator. If the raw value is saved, written back as the starting value and loaded, the computation resumes to the same result as an uninterrupted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wstrb | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |

## Verification
A corrupted accumulator can only be seen through the data register, so any error in the update, load or reflection path appears on the first data read after the faulty write, one cycle later. Known check values for two standard polynomials expose faults in polynomial handling and bit order together. Separate per-mode reads, compared against an independent model, tell the reflection variants apart. Faults in the mode or starting-value registers stay hidden until a readback of those registers or the next load, which is why the bench reads them back directly after it writes them.

// File: rtl/crc32_regblk_pkg.sv
package crc32_regblk_pkg;
  localparam int unsigned CRC_W = 32;
  localparam int unsigned LANES = CRC_W / 8;

  typedef enum logic [1:0] {
    REFL_NONE = 2'b00,
    REFL_BYTE = 2'b01,
    REFL_HALF = 2'b10,
    REFL_WORD = 2'b11
  } refl_mode_e;

  typedef struct packed {
    logic       out_rev;
    refl_mode_e in_mode;
  } ctrl_t;

  // Shift nbits of din (taken from the top of bits [nbits-1:0]) into crc.
  function automatic logic [CRC_W-1:0] crc_absorb(
    input logic [CRC_W-1:0] crc,
    input logic [CRC_W-1:0] din,
    input logic [CRC_W-1:0] poly,
    input int unsigned      nbits
  );
    logic [CRC_W-1:0] r;
    logic fb;
    r = crc;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      if (i < int'(nbits)) begin
        fb = r[CRC_W-1] ^ din[i];
        r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
    end
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] bit_reverse(input logic [CRC_W-1:0] x);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < int'(CRC_W); i++) r[i] = x[CRC_W-1-i];
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] lane_merge(
    input logic [CRC_W-1:0] old_v,
    input logic [CRC_W-1:0] new_v,
    input logic [LANES-1:0] strb
  );
    logic [CRC_W-1:0] r;
    r = old_v;
    for (int l = 0; l < int'(LANES); l++)
      if (strb[l]) r[l*8 +: 8] = new_v[l*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/crc32_in_reflect.sv
module crc32_in_reflect
  import crc32_regblk_pkg::*;
#(
  parameter int unsigned W = CRC_W
) (
  input  refl_mode_e     mode,
  input  logic           byte_wr,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout
);
  localparam int unsigned NB = W / 8;
  localparam int unsigned NH = W / 16;

  logic [W-1:0] by_byte, by_half, by_word;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    for (genvar b = 0; b < 8; b++) begin : g_bit
      assign by_byte[g*8 + b] = din[g*8 + 7 - b];
    end
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    for (genvar b = 0; b < 16; b++) begin : g_bit
      assign by_half[h*16 + b] = din[h*16 + 15 - b];
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_word
    assign by_word[b] = din[W - 1 - b];
  end

  always_comb begin
    if (byte_wr) begin
      dout = {din[W-1:8], (mode == REFL_NONE) ? din[7:0] : by_byte[7:0]};
    end else begin
      unique case (mode)
        REFL_BYTE: dout = by_byte;
        REFL_HALF: dout = by_half;
        REFL_WORD: dout = by_word;
        default:   dout = din;
      endcase
    end
  end
endmodule

// File: rtl/crc32_engine.sv
module crc32_engine
  import crc32_regblk_pkg::*;
(
  input  logic [CRC_W-1:0] acc,
  input  logic [CRC_W-1:0] din,
  input  logic [CRC_W-1:0] poly,
  output logic [CRC_W-1:0] nxt_byte,
  output logic [CRC_W-1:0] nxt_word
);
  assign nxt_byte = crc_absorb(acc, din, poly, 8);
  assign nxt_word = crc_absorb(acc, din, poly, CRC_W);
endmodule

// File: rtl/crc32_regblk.sv
module crc32_regblk
  import crc32_regblk_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 5,
  parameter logic [CRC_W-1:0]   INIT_RST = 32'hFFFF_FFFF,
  parameter logic [CRC_W-1:0]   POLY_RST = 32'h04C1_1DB7,
  parameter logic [ADDR_W-1:0]  OFS_DATA = 5'h00,
  parameter logic [ADDR_W-1:0]  OFS_CTRL = 5'h08,
  parameter logic [ADDR_W-1:0]  OFS_INIT = 5'h10,
  parameter logic [ADDR_W-1:0]  OFS_POLY = 5'h14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [LANES-1:0]   bus_wstrb,
  input  logic [CRC_W-1:0]   bus_wdata,
  output logic [CRC_W-1:0]   bus_rdata
);
  localparam int unsigned   CTL_LOAD = 0;
  localparam int unsigned   CTL_MLO  = 5;
  localparam int unsigned   CTL_OUT  = 7;
  localparam logic [LANES-1:0] STRB_BYTE = LANES'(1);
  localparam logic [LANES-1:0] STRB_WORD = '1;

  logic [CRC_W-1:0] acc_q, init_q, poly_q;
  ctrl_t            ctrl_q;

  // Named internal events
  logic wr, hit_data, hit_ctrl, hit_init, hit_poly;
  logic ev_word, ev_byte, ev_ctrl, ev_load;

  assign wr       = bus_sel & bus_we;
  assign hit_data = bus_addr == OFS_DATA;
  assign hit_ctrl = bus_addr == OFS_CTRL;
  assign hit_init = bus_addr == OFS_INIT;
  assign hit_poly = bus_addr == OFS_POLY;
  assign ev_word  = wr & hit_data & (bus_wstrb == STRB_WORD);
  assign ev_byte  = wr & hit_data & (bus_wstrb == STRB_BYTE);
  assign ev_ctrl  = wr & hit_ctrl & bus_wstrb[0];
  assign ev_load  = ev_ctrl & bus_wdata[CTL_LOAD];

  logic [CRC_W-1:0] din_refl, nxt_byte, nxt_word;

  crc32_in_reflect #(.W(CRC_W)) u_refl (
    .mode    (ctrl_q.in_mode),
    .byte_wr (ev_byte),
    .din     (bus_wdata),
    .dout    (din_refl)
  );

  crc32_engine u_eng (
    .acc      (acc_q),
    .din      (din_refl),
    .poly     (poly_q),
    .nxt_byte (nxt_byte),
    .nxt_word (nxt_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '1;
      init_q <= INIT_RST;
      poly_q <= POLY_RST;
      ctrl_q <= '0;
    end else begin
      if (ev_load)      acc_q <= init_q;
      else if (ev_word) acc_q <= nxt_word;
      else if (ev_byte) acc_q <= nxt_byte;

      if (ev_ctrl) begin
        ctrl_q.out_rev <= bus_wdata[CTL_OUT];
        ctrl_q.in_mode <= refl_mode_e'(bus_wdata[CTL_MLO +: 2]);
      end
      if (wr && hit_init) init_q <= lane_merge(init_q, bus_wdata, bus_wstrb);
      if (wr && hit_poly) poly_q <= lane_merge(poly_q, bus_wdata, bus_wstrb);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_data) begin
      bus_rdata = ctrl_q.out_rev ? bit_reverse(acc_q) : acc_q;
    end else if (hit_ctrl) begin
      bus_rdata[CTL_OUT]      = ctrl_q.out_rev;
      bus_rdata[CTL_MLO +: 2] = ctrl_q.in_mode;
    end else if (hit_init) begin
      bus_rdata = init_q;
    end else if (hit_poly) begin
      bus_rdata = poly_q;
    end
  end
endmodule

// File: rtl/crc32_regblk_chk.sv
module crc32_regblk_chk
  import crc32_regblk_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 5,
  parameter logic [ADDR_W-1:0] OFS_DATA = 5'h00,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 5'h08,
  parameter logic [ADDR_W-1:0] OFS_INIT = 5'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LANES-1:0]  bus_wstrb,
  input logic [CRC_W-1:0]  bus_wdata,
  input logic [CRC_W-1:0]  bus_rdata,
  input logic [CRC_W-1:0]  acc_q,
  input logic [CRC_W-1:0]  init_q,
  input logic              ev_load
);
  // R3
  load_takes_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> acc_q == $past(init_q));

  // R3
  ctrl_bit0_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL) |-> !bus_rdata[0]);

  // R10
  odd_strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_DATA && bus_wstrb != 4'hF && bus_wstrb != 4'h1)
    |=> $stable(acc_q));

  // R9
  mode_write_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_CTRL && !bus_wdata[0]) |=> $stable(acc_q));

  // R2
  init_write_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_INIT) |=> $stable(acc_q));

  // R11
  read_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> $stable(acc_q));
endmodule

bind crc32_regblk crc32_regblk_chk #(
  .ADDR_W   (ADDR_W),
  .OFS_DATA (OFS_DATA),
  .OFS_CTRL (OFS_CTRL),
  .OFS_INIT (OFS_INIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wstrb (bus_wstrb),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .acc_q     (acc_q),
  .init_q    (init_q),
  .ev_load   (ev_load)
);

// File: tb/crc32_regblk_bench.sv
module crc32_regblk_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  always #5 clk = ~clk;

  crc32_regblk u_crc32_regblk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wstrb (bus_wstrb),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // Reference model state
  logic [31:0] m_acc = 32'hFFFF_FFFF;
  logic [31:0] m_init = 32'hFFFF_FFFF;
  logic [31:0] m_poly = 32'h04C1_1DB7;
  logic        m_out = 1'b0;
  logic [1:0]  m_mode = 2'b00;

  function automatic logic [31:0] m_in(logic [31:0] d, logic [1:0] mode);
    int g;
    logic [31:0] r;
    case (mode)
      2'd0: g = 1;
      2'd1: g = 8;
      2'd2: g = 16;
      default: g = 32;
    endcase
    r = '0;
    for (int i = 0; i < 32; i++) r[(i / g) * g + g - 1 - (i % g)] = d[i];
    return r;
  endfunction

  // Polynomial long division: fold data into the top, then shift out.
  function automatic logic [31:0] m_div(logic [31:0] crc, logic [31:0] d, int nbits, logic [31:0] poly);
    logic [31:0] x;
    x = crc ^ (d << (32 - nbits));
    for (int k = 0; k < nbits; k++) x = x[31] ? ((x << 1) ^ poly) : (x << 1);
    return x;
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a)
      5'h00: return m_out ? m_in(m_acc, 2'd3) : m_acc;
      5'h08: return {24'h0, m_out, m_mode, 5'h0};
      5'h10: return m_init;
      5'h14: return m_poly;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    logic [31:0] r;
    r = o;
    for (int l = 0; l < 4; l++) if (s[l]) r[l*8 +: 8] = n[l*8 +: 8];
    return r;
  endfunction

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
    @(posedge clk); #2;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    case (a)
      5'h00: begin
        if (s == 4'hF) m_acc = m_div(m_acc, m_in(d, m_mode), 32, m_poly);
        else if (s == 4'h1)
          m_acc = m_div(m_acc, {24'h0, (m_mode != 2'd0) ? m_in(d, 2'd1) : d} & 32'hFF, 8, m_poly);
      end
      5'h08: if (s[0]) begin
        m_out = d[7]; m_mode = d[6:5];
        if (d[0]) m_acc = m_init;
      end
      5'h10: m_init = merge(m_init, d, s);
      5'h14: m_poly = merge(m_poly, d, s);
      default: ;
    endcase
  endtask

  task automatic wr_bytes(string s);
    for (int i = 0; i < s.len(); i++) wr(5'h00, {24'h0, s[i]}, 4'h1);
  endtask

  task automatic rd_lit(logic [4:0] a, logic [31:0] e, string tag);
    @(posedge clk); #2;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wstrb = '0;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic rd(logic [4:0] a, string tag);
    rd_lit(a, m_read(a), tag);
  endtask

  task automatic idle();
    @(posedge clk); #2;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  // Monitor: compare reads mid-cycle
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_we) begin
      logic [31:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read actual %h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s addr %h actual %h expected %h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] saved, final_v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset values, R2 unmapped offset
    rd_lit(5'h00, 32'hFFFF_FFFF, "R1 data");
    rd_lit(5'h08, 32'h0, "R1 ctrl");
    rd_lit(5'h10, 32'hFFFF_FFFF, "R1 init");
    rd_lit(5'h14, 32'h04C1_1DB7, "R1 poly");
    rd_lit(5'h04, 32'h0, "R2 unmapped");

    // R4 word absorb, R11 read right after write
    wr(5'h10, 32'h0); wr(5'h08, 32'h1);
    wr(5'h00, 32'hDEAD_BEEF);
    rd(5'h00, "R4 R11 word absorb");
    rd(5'h00, "R11 read is non-destructive");

    // R9 mode-only write keeps accumulator
    wr(5'h08, 32'h60);
    rd(5'h00, "R9 mode write");
    // R3 R8 control readback
    wr(5'h08, 32'hE1);
    rd_lit(5'h08, 32'hE0, "R3 R8 ctrl readback");

    // R2 lane writes, R3 load
    wr(5'h10, 32'h1234_5678);
    wr(5'h10, 32'h00AA_0000, 4'b0100);
    rd_lit(5'h10, 32'h12AA_5678, "R2 init lane strobe");
    wr(5'h08, 32'h01);
    rd_lit(5'h00, 32'h12AA_5678, "R3 load");

    // R5 R7 R8 byte input, reflected check value
    wr(5'h10, 32'hFFFF_FFFF); wr(5'h14, 32'h04C1_1DB7);
    wr(5'h08, 32'hA1);
    wr_bytes("123456789");
    rd_lit(5'h00, 32'h340B_C6D9, "R5 R7 R8 byte check value");

    // R6 R9 word then bytes in one message
    wr(5'h08, 32'hE1);
    wr(5'h00, 32'h3433_3231);
    wr(5'h08, 32'hA0);
    wr_bytes("56789");
    rd_lit(5'h00, 32'h340B_C6D9, "R6 R9 mixed widths");

    // R4 programmable polynomial
    wr(5'h14, 32'h1EDC_6F41);
    wr(5'h08, 32'hA1);
    wr_bytes("123456789");
    rd_lit(5'h00, 32'h1CF9_6D7C, "R4 second polynomial");

    // R6 each word reflection mode, R7 byte modes
    wr(5'h14, 32'h04C1_1DB7);
    for (int m = 0; m < 4; m++) begin
      wr(5'h08, 32'(m << 5) | 32'h1);
      wr(5'h00, 32'hA5C3_0F81);
      rd(5'h00, "R6 word reflection mode");
      wr(5'h00, 32'h0000_00C5, 4'h1);
      rd(5'h00, "R7 byte reflection mode");
    end

    // R10 odd strobes ignored
    wr(5'h00, 32'h1122_3344, 4'b0011);
    rd(5'h00, "R10 half strobe");
    wr(5'h00, 32'h1122_3344, 4'b1000);
    wr(5'h00, 32'h1122_3344, 4'b0000);
    rd(5'h00, "R10 other strobes");
    wr(5'h08, 32'hFF, 4'b0010);
    rd(5'h08, "R10 ctrl without lane 0");
    rd(5'h00, "R10 acc after ctrl lane miss");

    // R11 save and resume
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h08, 32'h01);
    wr(5'h00, 32'h0102_0304); wr(5'h00, 32'hCAFE_F00D);
    saved = m_acc;
    wr(5'h00, 32'h5555_AAAA);
    final_v = m_acc;
    rd_lit(5'h00, final_v, "R11 uninterrupted");
    wr(5'h08, 32'h01);
    wr(5'h00, 32'h0102_0304); wr(5'h00, 32'hCAFE_F00D);
    rd_lit(5'h00, saved, "R11 partial result");
    wr(5'h10, saved);
    wr(5'h08, 32'h01);
    wr(5'h00, 32'h5555_AAAA);
    rd_lit(5'h00, final_v, "R11 resumed");

    idle();
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL pending reads actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule